// File: doc/BRIEF.md
# Configuration Memory Soft-Error Scanner

This block walks a stored configuration image word by word through a simple read port, turns each returned word into a serial bit stream and folds the bits, one per clock, into a 32-bit CRC. When the last bit of the last word has been absorbed, the block compares the finished checksum with a golden value. It raises a sticky error flag if the two differ. The golden value is captured into an internal register when a scan launches.

The scan runs only while the enable input is high. A start pulse launches a single pass. With the repeat input set, the block launches the next pass by itself one cycle after each completion, so it scrubs the image in the background for as long as it stays enabled. Dropping enable aborts any pass and clears the status. A clear pulse drops the error flag without stopping anything.

Top module: `img_crc_scanner`

## Requirements
- R1: After reset, `busy`, `done`, `err_flag` and `rd_req` are all low.
- R2: The checksum uses the reflected CRC-32 polynomial (0x04C11DB7, applied right-shifting as 0xEDB88320). It is seeded with all ones, fed least significant bit of each word first at one bit per clock, and complemented at the end. For 8-bit words this equals the common CRC-32 of the bytes in address order.
- R3: Each pass issues exactly one `rd_req` cycle per word, at addresses 0, 1, …, 2^AW−1 in ascending order. `rd_data` is sampled in the cycle after `rd_req`.
- R4: When the finished checksum differs from the golden value captured at launch, `err_flag` rises in the same cycle as `done`.
- R5: A pass whose checksum matches the golden value leaves a low `err_flag` low.
- R6: Once set, `err_flag` stays high through later matching passes.
- R7: A one-cycle pulse on `clr_err` with `scan_en` high clears `err_flag` on the next edge. A clear takes priority over a mismatch in the same cycle.
- R8: With `scan_en` low, a running pass is abandoned, `busy` and `err_flag` are low one cycle later, and `scan_go` has no effect.
- R9: With `loop_mode` high, `busy` is high in the cycle right after `done`.
- R10: A `scan_go` pulse during a running pass is ignored, and the pass keeps its normal length.
- R11: `busy` stays high for exactly 2^AW·(DW+2) cycles per pass. `done` is a one-cycle pulse in the first cycle after `busy` falls.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| scan_en | input | 1 | Enables checking; low aborts a pass and clears status |
| scan_go | input | 1 | Launch pulse for one pass |
| loop_mode | input | 1 | Relaunch automatically after each completion |
| clr_err | input | 1 | Clears the sticky error flag |
| golden_crc | input | 32 | Expected checksum, captured at launch |
| rd_req | output | 1 | Read strobe toward the image memory |
| rd_addr | output | AW | Word address of the read |
| rd_data | input | DW | Word returned one cycle after `rd_req` |
| busy | output | 1 | A pass is in progress |
| done | output | 1 | One-cycle completion pulse |
| err_flag | output | 1 | Sticky checksum mismatch flag |

## Verification
The assertions assume that the memory returns a word exactly one cycle after each read strobe. They also assume that `golden_crc` is held steady only up to the launch edge, and that `clr_err` is a short pulse rather than a level. The stimulus models the memory as a registered array with that fixed latency. It changes every input on the falling clock edge, and it raises clear, start and enable changes only as single-cycle pulses or single edges. Abort and ignored-start cases are placed in the middle of a pass, well away from its completion cycle.

// File: rtl/imgscan_pkg.sv
package imgscan_pkg;
  localparam logic [31:0] CRC_POLY_REFL = 32'hEDB8_8320;
  localparam logic [31:0] CRC_SEED      = 32'hFFFF_FFFF;

  typedef enum logic [1:0] {ST_IDLE, ST_FETCH, ST_CAPT, ST_SHIFT} scan_state_e;

  // one serial bit into a right-shifting CRC register
  function automatic logic [31:0] crc_step(input logic [31:0] c, input logic b);
    crc_step = (c >> 1) ^ (((c[0] ^ b) == 1'b1) ? CRC_POLY_REFL : 32'h0);
  endfunction

  // final form of the checksum before compare
  function automatic logic [31:0] crc_final(input logic [31:0] c);
    crc_final = ~c;
  endfunction
endpackage

// File: rtl/img_scan_seq.sv
module img_scan_seq
  import imgscan_pkg::*;
#(
  parameter int AW = 4,
  parameter int DW = 8
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          scan_en,
  input  logic          scan_go,
  input  logic          loop_mode,
  input  logic          done_q,
  output logic          busy,
  output logic          rd_req,
  output logic [AW-1:0] rd_addr,
  output logic          launch,
  output logic          load,
  output logic          shift,
  output logic          last
);
  localparam int CW = (DW > 1) ? $clog2(DW) : 1;
  localparam logic [CW-1:0] BIT_LAST  = CW'(DW - 1);
  localparam logic [AW-1:0] WORD_LAST = '1;

  scan_state_e   state_q;
  logic [AW-1:0] word_q;
  logic [CW-1:0] bit_q;
  logic          bit_end;

  assign launch  = scan_en && (state_q == ST_IDLE) && (scan_go || (loop_mode && done_q));
  assign bit_end = (state_q == ST_SHIFT) && (bit_q == BIT_LAST);
  assign last    = bit_end && (word_q == WORD_LAST);
  assign busy    = (state_q != ST_IDLE);
  assign rd_req  = (state_q == ST_FETCH);
  assign rd_addr = word_q;
  assign load    = (state_q == ST_CAPT);
  assign shift   = (state_q == ST_SHIFT);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q <= ST_IDLE;
      word_q  <= '0;
      bit_q   <= '0;
    end else if (!scan_en) begin
      state_q <= ST_IDLE;
      word_q  <= '0;
      bit_q   <= '0;
    end else begin
      unique case (state_q)
        ST_IDLE: if (launch) begin
          state_q <= ST_FETCH;
          word_q  <= '0;
        end
        ST_FETCH: state_q <= ST_CAPT;
        ST_CAPT: begin
          state_q <= ST_SHIFT;
          bit_q   <= '0;
        end
        ST_SHIFT: begin
          bit_q <= bit_q + 1'b1;
          if (bit_end) begin
            if (word_q == WORD_LAST) begin
              state_q <= ST_IDLE;
            end else begin
              word_q  <= word_q + 1'b1;
              state_q <= ST_FETCH;
            end
          end
        end
        default: state_q <= ST_IDLE;
      endcase
    end
  end
endmodule

// File: rtl/img_scan_crc.sv
module img_scan_crc
  import imgscan_pkg::*;
#(
  parameter int DW = 8
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          init,
  input  logic          load,
  input  logic [DW-1:0] load_data,
  input  logic          shift,
  output logic [31:0]   crc_next
);
  logic [DW-1:0] shreg_q;
  logic [31:0]   crc_q;

  assign crc_next = crc_step(crc_q, shreg_q[0]);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      shreg_q <= '0;
      crc_q   <= CRC_SEED;
    end else begin
      if (init) crc_q <= CRC_SEED;
      if (load) shreg_q <= load_data;
      if (shift) begin
        shreg_q <= shreg_q >> 1;
        crc_q   <= crc_next;
      end
    end
  end
endmodule

// File: rtl/img_scan_cmp.sv
module img_scan_cmp
  import imgscan_pkg::*;
(
  input  logic        clk,
  input  logic        rst_n,
  input  logic        scan_en,
  input  logic        launch,
  input  logic        clr_err,
  input  logic        last,
  input  logic [31:0] crc_next,
  input  logic [31:0] golden_crc,
  output logic        mismatch,
  output logic        done,
  output logic        err_flag
);
  logic [31:0] golden_q;

  assign mismatch = (crc_final(crc_next) != golden_q);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      golden_q <= '0;
      done     <= 1'b0;
      err_flag <= 1'b0;
    end else if (!scan_en) begin
      done     <= 1'b0;
      err_flag <= 1'b0;
    end else begin
      if (launch) golden_q <= golden_crc;
      done <= last;
      if (clr_err) err_flag <= 1'b0;
      else if (last && mismatch) err_flag <= 1'b1;
    end
  end
endmodule

// File: rtl/img_crc_scanner.sv
module img_crc_scanner #(
  parameter int AW = 4,
  parameter int DW = 8
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          scan_en,
  input  logic          scan_go,
  input  logic          loop_mode,
  input  logic          clr_err,
  input  logic [31:0]   golden_crc,
  output logic          rd_req,
  output logic [AW-1:0] rd_addr,
  input  logic [DW-1:0] rd_data,
  output logic          busy,
  output logic          done,
  output logic          err_flag
);
  logic        scan_launch;
  logic        word_load;
  logic        bit_shift;
  logic        scan_last;
  logic        scan_mismatch;
  logic [31:0] crc_next;

  img_scan_seq #(.AW(AW), .DW(DW)) u_seq (
    .clk(clk), .rst_n(rst_n), .scan_en(scan_en), .scan_go(scan_go),
    .loop_mode(loop_mode), .done_q(done), .busy(busy), .rd_req(rd_req),
    .rd_addr(rd_addr), .launch(scan_launch), .load(word_load),
    .shift(bit_shift), .last(scan_last)
  );

  img_scan_crc #(.DW(DW)) u_crc (
    .clk(clk), .rst_n(rst_n), .init(scan_launch), .load(word_load),
    .load_data(rd_data), .shift(bit_shift), .crc_next(crc_next)
  );

  img_scan_cmp u_cmp (
    .clk(clk), .rst_n(rst_n), .scan_en(scan_en), .launch(scan_launch),
    .clr_err(clr_err), .last(scan_last), .crc_next(crc_next),
    .golden_crc(golden_crc), .mismatch(scan_mismatch), .done(done),
    .err_flag(err_flag)
  );
endmodule

// File: rtl/img_scan_chk.sv
module img_scan_chk (
  input logic clk,
  input logic rst_n,
  input logic scan_en,
  input logic scan_go,
  input logic loop_mode,
  input logic clr_err,
  input logic busy,
  input logic done,
  input logic err_flag,
  input logic rd_req,
  input logic scan_last,
  input logic scan_mismatch
);
  AST_DONE_SINGLE: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> !done); // R11
  AST_DONE_AFTER_LAST: assert property (@(posedge clk) disable iff (!rst_n)
    (scan_last && scan_en) |=> (done && !busy)); // R11
  AST_READ_IN_SCAN: assert property (@(posedge clk) disable iff (!rst_n)
    rd_req |-> busy); // R3
  AST_ERR_WITH_DONE: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(err_flag) |-> done); // R4
  AST_ERR_ON_MISMATCH: assert property (@(posedge clk) disable iff (!rst_n)
    (scan_last && scan_mismatch && scan_en && !clr_err) |=> err_flag); // R4
  AST_ERR_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
    (err_flag && scan_en && !clr_err) |=> err_flag); // R6
  AST_ERR_CLEAR: assert property (@(posedge clk) disable iff (!rst_n)
    clr_err |=> !err_flag); // R7
  AST_DISABLE_ABORT: assert property (@(posedge clk) disable iff (!rst_n)
    !scan_en |=> (!busy && !err_flag && !done)); // R8
  AST_LOOP_RELAUNCH: assert property (@(posedge clk) disable iff (!rst_n)
    (done && loop_mode && scan_en) |=> busy); // R9
  AST_GO_NO_EFFECT: assert property (@(posedge clk) disable iff (!rst_n)
    (busy && scan_go && scan_en && !scan_last) |=> busy); // R10
endmodule

bind img_crc_scanner img_scan_chk u_chk (
  .clk(clk), .rst_n(rst_n), .scan_en(scan_en), .scan_go(scan_go),
  .loop_mode(loop_mode), .clr_err(clr_err), .busy(busy), .done(done),
  .err_flag(err_flag), .rd_req(rd_req), .scan_last(scan_last),
  .scan_mismatch(scan_mismatch)
);

// File: tb/test_img_crc_scanner.sv
module test_img_crc_scanner;
  localparam int AW = 4;
  localparam int DW = 8;
  localparam int NW = 1 << AW;
  localparam int SCAN_LEN = NW * (DW + 2);

  logic          clk = 1'b0;
  logic          rst_n = 1'b0;
  logic          scan_en = 1'b0, scan_go = 1'b0, loop_mode = 1'b0, clr_err = 1'b0;
  logic [31:0]   golden_crc = '0;
  logic          rd_req;
  logic [AW-1:0] rd_addr;
  logic [DW-1:0] rd_data = '0;
  logic          busy, done, err_flag;

  logic [DW-1:0] mem [NW];
  int total = 0, bad = 0, cyc = 0, addr_bad = 0, rd_idx = 0;

  always #2.5 clk = ~clk;

  img_crc_scanner #(.AW(AW), .DW(DW)) i_img_crc_scanner (
    .clk(clk), .rst_n(rst_n), .scan_en(scan_en), .scan_go(scan_go),
    .loop_mode(loop_mode), .clr_err(clr_err), .golden_crc(golden_crc),
    .rd_req(rd_req), .rd_addr(rd_addr), .rd_data(rd_data),
    .busy(busy), .done(done), .err_flag(err_flag)
  );

  // memory with one-cycle read latency, and an address-order monitor (R3)
  always @(posedge clk) begin
    cyc <= cyc + 1;
    if (rd_req) rd_data <= mem[rd_addr];
    if (!busy) rd_idx <= 0;
    else if (rd_req) begin
      if (rd_addr != AW'(rd_idx)) addr_bad <= addr_bad + 1;
      rd_idx <= rd_idx + 1;
    end
  end

  always @(negedge clk) if (cyc > 100000) begin
    bad = bad + 1;
    total = total + 1;
    $display("FAIL watchdog: actual=%0d cycles expected<100000", cyc);
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  task automatic chk(input bit ok, input string tag, input longint act, input longint exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s: actual=0x%0h expected=0x%0h", tag, act, exp);
    end
  endtask

  // byte-at-a-time formulation of the standard CRC-32
  function automatic logic [31:0] ref_crc();
    logic [31:0] c = 32'hFFFF_FFFF;
    for (int w = 0; w < NW; w++) begin
      c = c ^ {24'h0, mem[w]};
      for (int k = 0; k < 8; k++) c = c[0] ? ((c >> 1) ^ 32'hEDB8_8320) : (c >> 1);
    end
    return ~c;
  endfunction

  // launch a pass, count busy cycles until done, return err at done
  task automatic run_pass(input logic [31:0] g, input int go_at, output int len, output logic e);
    int n = 0;
    @(negedge clk); golden_crc = g; scan_go = 1'b1;
    @(negedge clk); scan_go = 1'b0; golden_crc = ~g;
    len = 0;
    while (!done && n < 2000) begin
      if (busy) len++;
      if (n == go_at) scan_go = 1'b1; else scan_go = 1'b0;
      n++;
      @(negedge clk);
    end
    scan_go = 1'b0;
    e = err_flag;
  endtask

  task automatic t_reset();
    chk(!busy && !done && !err_flag && !rd_req, "R1 reset outputs", {busy, done, err_flag, rd_req}, 0);
  endtask

  task automatic t_match(input string tag);
    int len; logic e; int ab;
    ab = addr_bad;
    run_pass(ref_crc(), -1, len, e);
    chk(e == 1'b0, {"R2 R5 match ", tag}, e, 0);
    chk(len == SCAN_LEN, {"R11 length ", tag}, len, SCAN_LEN);
    chk(addr_bad == ab, {"R3 address order ", tag}, addr_bad - ab, 0);
    @(negedge clk);
    chk(!done && !busy, "R11 done single cycle", {done, busy}, 0);
  endtask

  task automatic t_mismatch();
    int len; logic e;
    run_pass(ref_crc() ^ 32'h0000_0100, -1, len, e);
    chk(e == 1'b1, "R4 mismatch sets err with done", e, 1);
  endtask

  task automatic t_sticky();
    int len; logic e;
    run_pass(ref_crc(), -1, len, e);
    chk(e == 1'b1, "R6 err sticky through passing scan", e, 1);
  endtask

  task automatic t_clear();
    @(negedge clk); clr_err = 1'b1;
    @(negedge clk); clr_err = 1'b0;
    chk(err_flag == 1'b0, "R7 clear pulse", err_flag, 0);
  endtask

  task automatic t_go_busy();
    int len; logic e;
    run_pass(ref_crc(), 50, len, e);
    chk(len == SCAN_LEN, "R10 start while busy ignored", len, SCAN_LEN);
    chk(e == 1'b0, "R10 result unchanged", e, 0);
  endtask

  task automatic t_disable();
    int len; logic e;
    run_pass(32'h1234_5678, -1, len, e);
    chk(e == 1'b1, "R4 err set before abort", e, 1);
    @(negedge clk); scan_go = 1'b1;
    @(negedge clk); scan_go = 1'b0;
    repeat (30) @(negedge clk);
    chk(busy == 1'b1, "R8 pass running before abort", busy, 1);
    scan_en = 1'b0;
    @(negedge clk);
    chk(!busy && !err_flag, "R8 abort clears busy and err", {busy, err_flag}, 0);
    scan_go = 1'b1;
    @(negedge clk); scan_go = 1'b0;
    repeat (3) @(negedge clk);
    chk(!busy && !rd_req, "R8 start ignored while disabled", {busy, rd_req}, 0);
    scan_en = 1'b1;
    @(negedge clk);
  endtask

  task automatic t_loop();
    int n = 0;
    loop_mode = 1'b1;
    golden_crc = ref_crc();
    @(negedge clk); scan_go = 1'b1;
    @(negedge clk); scan_go = 1'b0;
    while (!done && n < 2000) begin n++; @(negedge clk); end
    @(negedge clk);
    chk(busy == 1'b1, "R9 relaunch after done", busy, 1);
    loop_mode = 1'b0;
    n = 0;
    while (!done && n < 2000) begin n++; @(negedge clk); end
    chk(err_flag == 1'b0, "R9 second pass matches", err_flag, 0);
    @(negedge clk);
    chk(busy == 1'b0, "R9 stops when repeat off", busy, 0);
  endtask

  initial begin
    for (int w = 0; w < NW; w++) mem[w] = DW'(w * 37 + 5);
    repeat (3) @(negedge clk);
    t_reset();
    rst_n = 1'b1;
    @(negedge clk);
    t_reset();
    scan_en = 1'b1;
    @(negedge clk);
    t_match("ramp");
    for (int w = 0; w < NW; w++) mem[w] = (w % 2 == 0) ? 8'hFF : 8'h00;
    t_match("alternating");
    for (int w = 0; w < NW; w++) mem[w] = 8'h00;
    t_match("zeros");
    t_mismatch();
    t_sticky();
    t_clear();
    for (int w = 0; w < NW; w++) mem[w] = DW'(8'hA5 ^ (w << 3));
    t_go_busy();
    t_disable();
    t_loop();
    repeat (4) @(negedge clk);
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule